// File: doc/BRIEF.md
# CPU Address Window Decoder

This block translates addresses issued by a CPU master into a destination on the on-chip interconnect. It holds eight programmable decode windows. Each window pairs a control word with a base address, and the lowest-numbered windows also carry a remap register pair. Every window is aligned and sized in 64 KB units. Software programs the windows through a simple word-wide register port. Address lookups then proceed on a separate valid/address pair.

For each lookup, every window compares the upper sixteen address bits against its base, with its size mask applied, in the same cycle. The lowest-numbered enabled window that matches supplies the target ID and the attribute byte. The decoder reports a hit, or it reports a miss when no window matches. If the winning window can remap, the upper address half is replaced with the window's remap value. The result is registered, so it appears exactly one cycle after the lookup.

Top module: `cpu_win_decoder`

## Requirements
- R1: After reset, every register reads zero, every window is disabled and every lookup misses; with no lookup pending, out_valid=0 and out_target=4'hF.
- R2: Register offsets are window*16 plus field*4. The fields are: 0 control, 1 base, 2 remap-low, 3 remap-high. Reads return the value one cycle after reg_addr is presented. Control reads back as {mask[31:16], attr[15:8], target[7:4], 3'b000, enable[0]}. Base and remap-low read back with bits [15:0] cleared. Remap-high keeps all 32 bits. Writes to unaligned offsets or to offsets at or above 8*16 are ignored, and reads from such offsets return zero.
- R3: Window n matches when its enable bit is 1 and (lk_addr[31:16] & ~mask) equals base[31:16].
- R4: When several enabled windows match, the window with the lowest index wins.
- R5: A miss gives out_hit=0, out_miss=1, out_target=4'hF, out_attr=0, out_win=0 and out_addr=0.
- R6: A hit gives out_hit=1, out_miss=0, the winning index on out_win, and that window's target (bits [7:4]) and attribute (bits [15:8]).
- R7: When the winning window index is below NUM_REMAP (default 4), out_addr is {remap_low[31:16], lk_addr[15:0]}.
- R8: For windows at or above NUM_REMAP, the remap registers are absent. They read zero, writes to them are ignored, and a hit on such a window returns lk_addr unchanged.
- R9: out_valid is high in exactly the cycle after a cycle in which lk_valid was high.
- R10: A lookup presented in the same cycle as a register write uses the old settings. A lookup presented in the following cycle uses the new settings.
- R11: A window whose enable bit is 0 never matches, even if the address fits its range. Writing zero to its control word disables it.
- R12: When lk_valid was low in the previous cycle, out_hit and out_miss are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset, used for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | CPU address to decode |
| out_valid | output | 1 | Decode result valid |
| out_hit | output | 1 | An enabled window matched |
| out_miss | output | 1 | No enabled window matched |
| out_win | output | clog2(NUM_WIN) | Index of the winning window |
| out_target | output | 4 | Target ID of the winning window, 4'hF on a miss |
| out_attr | output | 8 | Attribute byte of the winning window |
| out_addr | output | 32 | Translated address |

## Verification
The assertions check the properties that hold on every cycle regardless of how the windows are programmed. These are the one-cycle valid latency, the exclusive hit/miss encoding with fixed miss values, the idle quiet outputs, and the rule that the low sixteen address bits pass through on every hit and that non-remapping windows pass the whole address through. The properties that depend on the programmed contents can only be shown by the bench's scenarios. These are the priority among overlapping windows, the masked range match, the effect of disabling a window, the register readback masks and the write-versus-lookup ordering. The bench shows them by sweeping the upper address half across two window configurations and comparing every result with an arithmetic model.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int GRAN_W = 16;

    localparam logic [3:0] TGT_DRAM   = 4'd0;
    localparam logic [3:0] TGT_DEVBUS = 4'd1;
    localparam logic [3:0] TGT_PCI    = 4'd3;
    localparam logic [3:0] TGT_PCIE   = 4'd4;
    localparam logic [3:0] TGT_NONE   = 4'hF;

    localparam logic [7:0] ATTR_IO  = 8'h51;
    localparam logic [7:0] ATTR_MEM = 8'h59;

    localparam logic [1:0] FLD_CTRL = 2'd0;
    localparam logic [1:0] FLD_BASE = 2'd1;
    localparam logic [1:0] FLD_RLO  = 2'd2;
    localparam logic [1:0] FLD_RHI  = 2'd3;

    typedef struct packed {
        logic              en;
        logic [3:0]        tgt;
        logic [7:0]        attr;
        logic [GRAN_W-1:0] mask;
        logic [GRAN_W-1:0] base;
        logic [GRAN_W-1:0] rlo;
    } win_cfg_t;

endpackage

// File: rtl/cwd_regfile.sv
module cwd_regfile
    import cwd_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4,
    parameter int REG_AW    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output win_cfg_t [NUM_WIN-1:0]    cfg_o
);
    localparam int IDX_W   = $clog2(NUM_WIN);
    localparam int WIN_LSB = 4;
    localparam int TOP_LSB = WIN_LSB + IDX_W;

    typedef struct packed {
        win_cfg_t [NUM_WIN-1:0]     win;
        logic [NUM_WIN-1:0][31:0]   rhi;
        logic [31:0]                rdata;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [IDX_W-1:0] sel_win;
    logic [1:0]       sel_fld;
    logic             in_map;
    logic             can_remap;

    always_comb begin
        st_d      = st_q;
        sel_win   = reg_addr[WIN_LSB +: IDX_W];
        sel_fld   = reg_addr[3:2];
        in_map    = ((reg_addr >> TOP_LSB) == '0) && (reg_addr[1:0] == 2'b00);
        can_remap = (32'(sel_win) < NUM_REMAP);

        st_d.rdata = '0;
        if (in_map) begin
            unique case (sel_fld)
                FLD_CTRL: st_d.rdata = {st_q.win[sel_win].mask, st_q.win[sel_win].attr,
                                        st_q.win[sel_win].tgt, 3'b000, st_q.win[sel_win].en};
                FLD_BASE: st_d.rdata = {st_q.win[sel_win].base, 16'h0000};
                FLD_RLO:  st_d.rdata = can_remap ? {st_q.win[sel_win].rlo, 16'h0000} : 32'h0;
                default:  st_d.rdata = can_remap ? st_q.rhi[sel_win] : 32'h0;
            endcase
        end

        if (reg_wr && in_map) begin
            unique case (sel_fld)
                FLD_CTRL: begin
                    st_d.win[sel_win].mask = reg_wdata[31:16];
                    st_d.win[sel_win].attr = reg_wdata[15:8];
                    st_d.win[sel_win].tgt  = reg_wdata[7:4];
                    st_d.win[sel_win].en   = reg_wdata[0];
                end
                FLD_BASE: st_d.win[sel_win].base = reg_wdata[31:16];
                FLD_RLO: begin
                    if (can_remap) st_d.win[sel_win].rlo = reg_wdata[31:16];
                end
                default: begin
                    if (can_remap) st_d.rhi[sel_win] = reg_wdata;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign cfg_o     = st_q.win;

endmodule

// File: rtl/cwd_win_cmp.sv
module cwd_win_cmp
    import cwd_pkg::*;
(
    input  logic              en_i,
    input  logic [GRAN_W-1:0] mask_i,
    input  logic [GRAN_W-1:0] base_i,
    input  logic [GRAN_W-1:0] addr_hi_i,
    output logic              match_o
);
    always_comb begin
        match_o = en_i && ((addr_hi_i & ~mask_i) == base_i);
    end
endmodule

// File: rtl/cwd_select.sv
module cwd_select
    import cwd_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4
) (
    input  logic [NUM_WIN-1:0]              match_i,
    input  logic [NUM_WIN-1:0][3:0]         tgt_i,
    input  logic [NUM_WIN-1:0][7:0]         attr_i,
    input  logic [NUM_WIN-1:0][GRAN_W-1:0]  rlo_i,
    input  logic [31:0]                     addr_i,
    output logic                            hit_o,
    output logic [$clog2(NUM_WIN)-1:0]      idx_o,
    output logic [3:0]                      tgt_o,
    output logic [7:0]                      attr_o,
    output logic [31:0]                     addr_o
);
    localparam int IDX_W = $clog2(NUM_WIN);

    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        tgt_o  = TGT_NONE;
        attr_o = '0;
        addr_o = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                hit_o  = 1'b1;
                idx_o  = IDX_W'(i);
                tgt_o  = tgt_i[i];
                attr_o = attr_i[i];
                addr_o = (i < NUM_REMAP) ? {rlo_i[i], addr_i[15:0]} : addr_i;
            end
        end
    end
endmodule

// File: rtl/cpu_win_decoder.sv
module cpu_win_decoder
    import cwd_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4,
    parameter int REG_AW    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    input  logic                        lk_valid,
    input  logic [31:0]                 lk_addr,
    output logic                        out_valid,
    output logic                        out_hit,
    output logic                        out_miss,
    output logic [$clog2(NUM_WIN)-1:0]  out_win,
    output logic [3:0]                  out_target,
    output logic [7:0]                  out_attr,
    output logic [31:0]                 out_addr
);
    localparam int IDX_W = $clog2(NUM_WIN);

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             miss;
        logic [IDX_W-1:0] win;
        logic [3:0]       tgt;
        logic [7:0]       attr;
        logic [31:0]      addr;
    } res_t;

    localparam res_t RES_IDLE = '{valid: 1'b0, hit: 1'b0, miss: 1'b0, win: '0,
                                  tgt: TGT_NONE, attr: '0, addr: '0};

    win_cfg_t [NUM_WIN-1:0]             cfg;
    logic [NUM_WIN-1:0]                 match;
    logic [NUM_WIN-1:0][3:0]            tgt_v;
    logic [NUM_WIN-1:0][7:0]            attr_v;
    logic [NUM_WIN-1:0][GRAN_W-1:0]     rlo_v;

    logic             sel_hit;
    logic [IDX_W-1:0] sel_idx;
    logic [3:0]       sel_tgt;
    logic [7:0]       sel_attr;
    logic [31:0]      sel_addr;

    res_t res_d, res_q;

    cwd_regfile #(
        .NUM_WIN  (NUM_WIN),
        .NUM_REMAP(NUM_REMAP),
        .REG_AW   (REG_AW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cfg_o    (cfg)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        cwd_win_cmp u_cmp (
            .en_i     (cfg[g].en),
            .mask_i   (cfg[g].mask),
            .base_i   (cfg[g].base),
            .addr_hi_i(lk_addr[31:16]),
            .match_o  (match[g])
        );
        assign tgt_v[g]  = cfg[g].tgt;
        assign attr_v[g] = cfg[g].attr;
        assign rlo_v[g]  = cfg[g].rlo;
    end

    cwd_select #(
        .NUM_WIN  (NUM_WIN),
        .NUM_REMAP(NUM_REMAP)
    ) u_sel (
        .match_i(match),
        .tgt_i  (tgt_v),
        .attr_i (attr_v),
        .rlo_i  (rlo_v),
        .addr_i (lk_addr),
        .hit_o  (sel_hit),
        .idx_o  (sel_idx),
        .tgt_o  (sel_tgt),
        .attr_o (sel_attr),
        .addr_o (sel_addr)
    );

    always_comb begin
        res_d = RES_IDLE;
        if (lk_valid) begin
            res_d.valid = 1'b1;
            res_d.hit   = sel_hit;
            res_d.miss  = !sel_hit;
            res_d.win   = sel_idx;
            res_d.tgt   = sel_tgt;
            res_d.attr  = sel_attr;
            res_d.addr  = sel_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= RES_IDLE;
        else        res_q <= res_d;
    end

    assign out_valid  = res_q.valid;
    assign out_hit    = res_q.hit;
    assign out_miss   = res_q.miss;
    assign out_win    = res_q.win;
    assign out_target = res_q.tgt;
    assign out_attr   = res_q.attr;
    assign out_addr   = res_q.addr;

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        lk_valid,
    input logic [31:0]                 lk_addr,
    input logic                        out_valid,
    input logic                        out_hit,
    input logic                        out_miss,
    input logic [$clog2(NUM_WIN)-1:0]  out_win,
    input logic [3:0]                  out_target,
    input logic [7:0]                  out_attr,
    input logic [31:0]                 out_addr
);
    // R9
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> out_valid);

    // R9
    lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !out_valid);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_hit && !out_miss));

    // R5
    hit_xor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hit != out_miss));

    // R5
    miss_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> (out_target == 4'hF && out_attr == 8'h00 && out_addr == 32'h0));

    // R7
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (out_addr[15:0] == $past(lk_addr[15:0])));

    // R8
    no_remap_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hit && (32'(out_win) >= NUM_REMAP)) |-> (out_addr == $past(lk_addr)));

endmodule

bind cpu_win_decoder cwd_checker #(
    .NUM_WIN  (NUM_WIN),
    .NUM_REMAP(NUM_REMAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_miss  (out_miss),
    .out_win   (out_win),
    .out_target(out_target),
    .out_attr  (out_attr),
    .out_addr  (out_addr)
);

// File: tb/tb_cpu_win_decoder.sv
`timescale 1ns/1ps
module tb_cpu_win_decoder;
    localparam int NW = 8;
    localparam int NR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        out_valid, out_hit, out_miss;
    logic [2:0]  out_win;
    logic [3:0]  out_target;
    logic [7:0]  out_attr;
    logic [31:0] out_addr;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] m_ctrl [NW];
    logic [31:0] m_base [NW];
    logic [31:0] m_rlo  [NW];
    logic [31:0] m_rhi  [NW];

    always #2.5 clk = ~clk;

    cpu_win_decoder #(.NUM_WIN(NW), .NUM_REMAP(NR), .REG_AW(8)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .out_valid(out_valid), .out_hit(out_hit),
        .out_miss(out_miss), .out_win(out_win), .out_target(out_target),
        .out_attr(out_attr), .out_addr(out_addr)
    );

    function automatic void m_write(int a, logic [31:0] d);
        int w, f;
        if (a[1:0] != 0 || a >= NW * 16) return;
        w = a / 16;
        f = (a / 4) % 4;
        case (f)
            0: m_ctrl[w] = d & 32'hFFFF_FFF1;
            1: m_base[w] = d & 32'hFFFF_0000;
            2: if (w < NR) m_rlo[w] = d & 32'hFFFF_0000;
            default: if (w < NR) m_rhi[w] = d;
        endcase
    endfunction

    function automatic logic [31:0] m_read(int a);
        int w, f;
        if (a[1:0] != 0 || a >= NW * 16) return 32'h0;
        w = a / 16;
        f = (a / 4) % 4;
        case (f)
            0: return m_ctrl[w];
            1: return m_base[w];
            2: return m_rlo[w];
            default: return m_rhi[w];
        endcase
    endfunction

    function automatic logic [49:0] m_lookup(logic [31:0] a);
        logic [49:0] r;
        r = {1'b1, 1'b0, 1'b1, 3'd0, 4'hF, 8'h00, 32'h0};
        for (int w = NW - 1; w >= 0; w--) begin
            if (m_ctrl[w][0] && ((a[31:16] & ~m_ctrl[w][31:16]) == m_base[w][31:16])) begin
                r = {1'b1, 1'b1, 1'b0, 3'(w), m_ctrl[w][7:4], m_ctrl[w][15:8],
                     (w < NR) ? {m_rlo[w][31:16], a[15:0]} : a};
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] mk_ctrl(logic [15:0] mask, logic [7:0] attr,
                                            logic [3:0] tgt, logic en);
        return {mask, attr, tgt, 3'b111, en};
    endfunction

    task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_out(string req, logic [49:0] exp);
        logic [49:0] act;
        act = {out_valid, out_hit, out_miss, out_win, out_target, out_attr, out_addr};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        m_write(a, d);
    endtask

    task automatic rd_chk(string req, int a);
        @(negedge clk);
        reg_addr = 8'(a);
        @(negedge clk);
        chk32(req, reg_rdata, m_read(a));
    endtask

    task automatic look(string req, logic [31:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        chk_out(req, m_lookup(a));
        lk_valid = 1'b0;
    endtask

    task automatic sweep(string req, int stride);
        logic [31:0] prev;
        logic        pend;
        pend = 1'b0;
        prev = '0;
        for (int hi = 0; hi < 65536; hi += stride) begin
            @(negedge clk);
            if (pend) chk_out(req, m_lookup(prev));
            prev = {16'(hi), 16'(hi) ^ 16'h5A3C};
            lk_valid = 1'b1; lk_addr = prev; pend = 1'b1;
        end
        @(negedge clk);
        chk_out(req, m_lookup(prev));
        lk_valid = 1'b0;
    endtask

    task automatic program_a();
        wr(8'h00, mk_ctrl(16'h00FF, 8'h51, 4'd4, 1'b1)); wr(8'h04, 32'h1000_1234);
        wr(8'h08, 32'hA000_FFFF); wr(8'h0C, 32'h0000_0001);
        wr(8'h10, mk_ctrl(16'h000F, 8'h51, 4'd3, 1'b1)); wr(8'h14, 32'h1100_0000);
        wr(8'h18, 32'h0020_0000);
        wr(8'h20, mk_ctrl(16'h0FFF, 8'h59, 4'd4, 1'b1)); wr(8'h24, 32'h2000_0000);
        wr(8'h28, 32'h2000_0000);
        wr(8'h30, mk_ctrl(16'h003F, 8'h59, 4'd3, 1'b1)); wr(8'h34, 32'h1040_0000);
        wr(8'h38, 32'hB000_0000);
        wr(8'h40, mk_ctrl(16'h00FF, 8'h0F, 4'd1, 1'b1)); wr(8'h44, 32'hFF00_0000);
        wr(8'h48, 32'hCCCC_0000);
        wr(8'h50, mk_ctrl(16'h0000, 8'h1E, 4'd1, 1'b0)); wr(8'h54, 32'h4000_0000);
        wr(8'h60, mk_ctrl(16'h0003, 8'h1D, 4'd1, 1'b1)); wr(8'h64, 32'h4000_0000);
        wr(8'h70, mk_ctrl(16'h00FF, 8'h1B, 4'd1, 1'b1)); wr(8'h74, 32'h2100_0000);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int w = 0; w < NW; w++) begin
            m_ctrl[w] = '0; m_base[w] = '0; m_rlo[w] = '0; m_rhi[w] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports and in every register
        @(negedge clk);
        chk_out("R1", {1'b0, 1'b0, 1'b0, 3'd0, 4'hF, 8'h00, 32'h0});
        for (int a = 0; a < NW * 16; a += 4) rd_chk("R1", a);
        look("R1/R5", 32'h0000_0000);
        look("R1/R5", 32'hFFFF_FFFF);

        // R2 and R8: readback masks, absent remap registers, unmapped offsets
        for (int a = 0; a < NW * 16; a += 4) wr(a, 32'hFFFF_FFFF);
        for (int a = 0; a < NW * 16; a += 4) rd_chk("R2/R8", a);
        wr(8'h82, 32'h1234_5678);
        wr(8'h81, 32'h1234_5678);
        rd_chk("R2", 8'h80);
        rd_chk("R2", 8'h00);
        for (int a = 0; a < NW * 16; a += 4) wr(a, 32'h0);
        for (int a = 0; a < NW * 16; a += 4) rd_chk("R11", a);
        look("R11", 32'h0000_0000);

        // R3 R4 R6 R7 R8 R11: configuration A, full sweep of upper half
        program_a();
        rd_chk("R8", 8'h48);
        look("R4", 32'h1050_0000);
        look("R7", 32'h10FF_ABCD);
        look("R3", 32'h1100_0000);
        look("R3", 32'h1110_0000);
        look("R8", 32'hFF80_0042);
        look("R11", 32'h4000_0001);
        sweep("R3/R4/R6/R7/R8", 1);

        // R12: idle cycle after lookups
        @(negedge clk);
        chk_out("R12", {1'b0, 1'b0, 1'b0, 3'd0, 4'hF, 8'h00, 32'h0});

        // R10: write and lookup in the same cycle, then lookup next cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h60; reg_wdata = 32'h0;
        lk_valid = 1'b1; lk_addr = 32'h4002_1234;
        @(negedge clk);
        chk_out("R10", {1'b1, 1'b1, 1'b0, 3'd6, 4'd1, 8'h1D, 32'h4002_1234});
        reg_wr = 1'b0;
        m_write(8'h60, 32'h0);
        @(negedge clk);
        chk_out("R10", {1'b1, 1'b0, 1'b1, 3'd0, 4'hF, 8'h00, 32'h0});
        lk_valid = 1'b0;

        // R11 R4: configuration B, window 0 disabled by zero writes
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h50, mk_ctrl(16'h0001, 8'h1E, 4'd1, 1'b1));
        look("R11/R4", 32'h1050_0000);
        look("R5", 32'h10C0_0000);
        sweep("R3/R4/R11", 3);

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule